// File: doc/BRIEF.md
# GPIO bank array with per-pin interrupt detection

A set of identical 32-pin general-purpose I/O banks reached over a plain 32-bit register bus (address, write strobe, write data, combinational read data). For every pin the block holds an output value and an output enable, brings the pad level in through a two-stage synchronizer, and runs an interrupt detector. The pad itself is not modelled: the drive value, drive enable and sampled input are three separate pin vectors.

Each pin's detector is programmed with three independent bits: one picks level or edge sensing, one picks dual-edge sensing, and one sets the polarity (rising edge or high level versus falling edge or low level). Detected events land in a sticky raw status bit. A per-pin enable mask qualifies the status, and the qualified status of every pin in every bank is ORed onto a single interrupt line. Status is cleared by writing ones. Bank b occupies the address window starting at b × 0x200; pin n belongs to bank n/32 at bit n%32.

Top module: `gpio_bank_array`

## Requirements
- R1: After reset every readable register in every bank reads zero, pin_out and pin_oe are all zero and irq is low.
- R2: Offset 0x04 holds the output values and 0x08 the output enables. Both read back what was written, and bit i of bank b appears on pin_out and pin_oe bit 32·b+i. An enable bit of 1 means the pin is driven.
- R3: Offset 0x00 is read-only and shows the synchronized pin inputs. A change on pin_in that is set up before clock edge k is not visible after edge k and is visible after edge k+1. Bank b is decoded at base address b·0x200.
- R4: A 1 in the type register (0x0C) selects level sensing. The raw status bit is then 1 while the synchronized pin is at its active level and 0 otherwise. The polarity register (0x14) sets the active level: 1 means high and 0 means low.
- R5: A 0 in the type register selects edge sensing. With dual-edge (0x10) at 0, polarity 1 captures rising edges and polarity 0 captures falling edges. A captured edge stays in the status bit until it is cleared.
- R6: In edge mode with the dual-edge bit set, both rising and falling transitions set the status bit, whatever the polarity bit holds.
- R7: Raw status is read at 0x1C. Writing a 1 to a bit of 0x24 clears that status bit, and writing 0 leaves it unchanged. 0x24 always reads zero. A level-mode bit whose level is still active reads 0 on the cycle after the clear and reads 1 again one cycle later.
- R8: When an edge event and a clear of the same bit occur in the same cycle, the bit ends up set.
- R9: Offset 0x18 holds the interrupt enables, where 1 means enabled. Offset 0x20 reads raw status ANDed with the enables.
- R10: irq is high exactly when at least one enabled status bit is set in any bank. It stays low while all enables are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe; the write takes effect at the next clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | 32·NUM_BANKS | Pad input levels, asynchronous |
| pin_out | output | 32·NUM_BANKS | Output values |
| pin_oe | output | 32·NUM_BANKS | Output enables |
| irq | output | 1 | Combined interrupt |

## Verification
The trigger check is a sweep across both banks that rotates all eight combinations of type, dual-edge and polarity over the pins. Each pass takes the pins through four phases: quiet low, toggled high, cleared while still high, and returned low. The phases separate edge pins from level pins, rising pins from falling pins, and sticky behaviour from level-following behaviour. Different toggle masks and enable masks per pass keep neighbouring pins and banks distinct, and one pass uses an all-zero enable mask to show that irq stays low. Directed sequences then place a clear in the same cycle as an edge event, write zeros to the clear register, watch a level bit during the two cycles after its clear, and time the input register against the synchronizer delay.

// File: rtl/gpio_bank_array.sv
`timescale 1ns/1ps
module gpio_bank_array #(
  parameter int NUM_BANKS   = 2,
  parameter int ADDR_W      = 12,
  parameter int BANK_STRIDE = 512,
  localparam int NPINS      = NUM_BANKS * 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);
  localparam int OFS_W = $clog2(BANK_STRIDE);
  localparam int BSEL_W = ADDR_W - OFS_W;
  localparam logic [OFS_W-1:0] REG_DIN  = OFS_W'('h00);
  localparam logic [OFS_W-1:0] REG_DOUT = OFS_W'('h04);
  localparam logic [OFS_W-1:0] REG_OE   = OFS_W'('h08);
  localparam logic [OFS_W-1:0] REG_TYPE = OFS_W'('h0C);
  localparam logic [OFS_W-1:0] REG_DUAL = OFS_W'('h10);
  localparam logic [OFS_W-1:0] REG_POL  = OFS_W'('h14);
  localparam logic [OFS_W-1:0] REG_EN   = OFS_W'('h18);
  localparam logic [OFS_W-1:0] REG_RAW  = OFS_W'('h1C);
  localparam logic [OFS_W-1:0] REG_QUAL = OFS_W'('h20);
  localparam logic [OFS_W-1:0] REG_CLR  = OFS_W'('h24);

  logic [NPINS-1:0] dout_q, oe_q, type_q, dual_q, pol_q, en_q, stat_q;
  logic [NPINS-1:0] sy1_q, sy2_q, last_q;
  logic [NPINS-1:0] clr_v, rise, fall, edge_hit, lvl_hit, stat_d, qual;
  logic [NUM_BANKS-1:0] bank_we;

  wire [BSEL_W-1:0] bsel = bus_addr[ADDR_W-1:OFS_W];
  wire [OFS_W-1:0]  rofs = bus_addr[OFS_W-1:0];
  wire              bank_ok = int'(bsel) < NUM_BANKS;

  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      bank_we[b] = bus_we && (bsel == BSEL_W'(b));
      clr_v[b*32 +: 32] = (bank_we[b] && rofs == REG_CLR) ? bus_wdata : 32'h0;
    end
  end

  assign rise     = sy2_q & ~last_q;
  assign fall     = ~sy2_q & last_q;
  assign edge_hit = (dual_q & (rise | fall)) | (~dual_q & pol_q & rise) | (~dual_q & ~pol_q & fall);
  assign lvl_hit  = (pol_q & sy2_q) | (~pol_q & ~sy2_q);
  assign stat_d   = (type_q & lvl_hit & ~clr_v) | (~type_q & (edge_hit | (stat_q & ~clr_v)));
  assign qual     = stat_q & en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0; oe_q <= '0; type_q <= '0; dual_q <= '0;
      pol_q  <= '0; en_q <= '0; stat_q <= '0;
      sy1_q  <= '0; sy2_q <= '0; last_q <= '0;
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (bank_we[b]) begin
          case (rofs)
            REG_DOUT: dout_q[b*32 +: 32] <= bus_wdata;
            REG_OE:   oe_q[b*32 +: 32]   <= bus_wdata;
            REG_TYPE: type_q[b*32 +: 32] <= bus_wdata;
            REG_DUAL: dual_q[b*32 +: 32] <= bus_wdata;
            REG_POL:  pol_q[b*32 +: 32]  <= bus_wdata;
            REG_EN:   en_q[b*32 +: 32]   <= bus_wdata;
            default: ;
          endcase
        end
      end
      sy1_q  <= pin_in;
      sy2_q  <= sy1_q;
      last_q <= sy2_q;
      stat_q <= stat_d;
    end
  end

  always_comb begin
    bus_rdata = 32'h0;
    if (bank_ok) begin
      case (rofs)
        REG_DIN:  bus_rdata = sy2_q[int'(bsel)*32 +: 32];
        REG_DOUT: bus_rdata = dout_q[int'(bsel)*32 +: 32];
        REG_OE:   bus_rdata = oe_q[int'(bsel)*32 +: 32];
        REG_TYPE: bus_rdata = type_q[int'(bsel)*32 +: 32];
        REG_DUAL: bus_rdata = dual_q[int'(bsel)*32 +: 32];
        REG_POL:  bus_rdata = pol_q[int'(bsel)*32 +: 32];
        REG_EN:   bus_rdata = en_q[int'(bsel)*32 +: 32];
        REG_RAW:  bus_rdata = stat_q[int'(bsel)*32 +: 32];
        REG_QUAL: bus_rdata = qual[int'(bsel)*32 +: 32];
        default:  bus_rdata = 32'h0;
      endcase
    end
  end

  assign pin_out = dout_q;
  assign pin_oe  = oe_q;
  assign irq     = |qual;
endmodule

// File: rtl/gpio_bank_array_chk.sv
`timescale 1ns/1ps
module gpio_bank_array_chk #(
  parameter int NPINS = 64,
  parameter int ADDR_W = 12,
  parameter int OFS_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [31:0]       bus_rdata,
  input logic [NPINS-1:0]  pin_oe,
  input logic              irq,
  input logic [NPINS-1:0]  stat,
  input logic [NPINS-1:0]  kind,
  input logic [NPINS-1:0]  clr,
  input logic [NPINS-1:0]  en
);
  wire [OFS_W-1:0] ofs = bus_addr[OFS_W-1:0];

  a_r7_clear_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ofs == OFS_W'('h24)) |-> (bus_rdata == 32'h0));

  a_r2_oe_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && ofs == OFS_W'('h08)) |=> $stable(pin_oe));

  a_r5_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(stat) & ~$past(kind) & ~$past(clr)) & ~stat) == '0));

  a_r10_no_enable_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !irq);

  a_r10_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((stat & en) != '0));
endmodule

bind gpio_bank_array gpio_bank_array_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_rdata(bus_rdata),
  .pin_oe(pin_oe), .irq(irq), .stat(stat_q), .kind(type_q), .clr(clr_v), .en(en_q)
);

// File: tb/gpio_bank_array_bench.sv
`timescale 1ns/1ps
module gpio_bank_array_bench;
  localparam int NB = 2;
  localparam int NP = NB * 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic irq;
  int nvec = 0;
  int nbad = 0;
  bit done = 0;

  gpio_bank_array u_gpio_bank_array (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
    .bus_rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; we = 1'b1; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic expect_bit(input logic [2:0] c, input logic r, input logic f, input logic l);
    if (c[2]) return c[0] ? l : ~l;
    if (c[1]) return r | f;
    return c[0] ? r : f;
  endfunction

  function automatic logic [2:0] cfg_of(input int pin, input int p);
    return 3'((pin + p) % 8);
  endfunction

  task automatic check_raw(input string tag, input int p, input logic [NP-1:0] r,
                           input logic [NP-1:0] f, input logic [NP-1:0] l);
    logic [31:0] v, e;
    for (int b = 0; b < NB; b++) begin
      e = '0;
      for (int i = 0; i < 32; i++) e[i] = expect_bit(cfg_of(b*32+i, p), r[b*32+i], f[b*32+i], l[b*32+i]);
      rd(12'(b*512 + 'h1C), v);
      chk($sformatf("%s pass %0d bank %0d", tag, p, b), v, e);
    end
  endtask

  initial begin
    logic [31:0] v;
    logic [NP-1:0] pat, tog, msk, e64;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    for (int b = 0; b < NB; b++)
      for (int o = 0; o <= 'h24; o += 4) begin
        rd(12'(b*512 + o), v);
        chk($sformatf("R1 reset bank %0d ofs %h", b, o), v, 32'h0);
      end
    chk("R1 reset pin_out", pin_out[31:0] | pin_out[63:32], 32'h0);
    chk("R1 reset pin_oe", pin_oe[31:0] | pin_oe[63:32], 32'h0);
    chk("R1 reset irq", 32'(irq), 32'h0);

    pat = 64'h3C96_E15A_C33C_0FF0;
    for (int b = 0; b < NB; b++) begin
      wr(12'(b*512 + 'h04), pat[b*32 +: 32]);
      wr(12'(b*512 + 'h08), ~pat[b*32 +: 32] ^ 32'h0101_0101);
    end
    for (int b = 0; b < NB; b++) begin
      rd(12'(b*512 + 'h04), v); chk($sformatf("R2 dout readback bank %0d", b), v, pat[b*32 +: 32]);
      rd(12'(b*512 + 'h08), v); chk($sformatf("R2 oe readback bank %0d", b), v, ~pat[b*32 +: 32] ^ 32'h0101_0101);
      chk($sformatf("R2 pin_out bank %0d", b), pin_out[b*32 +: 32], pat[b*32 +: 32]);
      chk($sformatf("R2 pin_oe bank %0d", b), pin_oe[b*32 +: 32], ~pat[b*32 +: 32] ^ 32'h0101_0101);
    end

    @(negedge clk); pin_in = 64'h1234_5678_9ABC_DEF0; addr = 12'h000;
    @(negedge clk); #1 chk("R3 din after one edge", rdata, 32'h0);
    @(negedge clk); #1 chk("R3 din after two edges", rdata, 32'h9ABC_DEF0);
    rd(12'h200, v); chk("R3 din bank 1", v, 32'h1234_5678);
    @(negedge clk); pin_in = '0;
    idle(4);

    wr(12'h00C, 32'h0); wr(12'h010, 32'h0); wr(12'h014, 32'h1);
    wr(12'h024, 32'hFFFF_FFFF);
    idle(3);
    @(negedge clk); pin_in[0] = 1'b1;
    @(negedge clk);
    wr(12'h024, 32'h1);
    rd(12'h01C, v); chk("R8 event beats same-cycle clear", v, 32'h1);
    wr(12'h024, 32'h0);
    rd(12'h01C, v); chk("R7 zero write keeps status", v, 32'h1);
    rd(12'h024, v); chk("R7 clear register reads zero", v, 32'h0);
    wr(12'h024, 32'h1);
    rd(12'h01C, v); chk("R7 one write clears status", v, 32'h0);
    rd(12'h01C, v); chk("R5 rising edge sticks only once", v, 32'h0);

    wr(12'h00C, 32'h2); wr(12'h014, 32'h3);
    @(negedge clk); pin_in[1] = 1'b1;
    idle(4);
    rd(12'h01C, v); chk("R4 level high sets status", v, 32'h2);
    @(negedge clk); addr = 12'h024; we = 1'b1; wdata = 32'h2;
    @(negedge clk); we = 1'b0; addr = 12'h01C;
    #1 chk("R7 level bit low right after clear", rdata, 32'h0);
    @(negedge clk); #1 chk("R7 level bit reasserts", rdata, 32'h2);
    @(negedge clk); pin_in = '0;
    idle(4);

    // R4 R5 R6 R9 R10 sweep over all trigger settings
    for (int p = 0; p < 8; p++) begin
      pat = 64'h5A3C_96E1_0FF0_C33C;
      tog = (p % 2 == 0) ? '1 : ((pat << p) | (pat >> (64 - p)));
      msk = (p == 3) ? '0 : ((p % 2 == 1) ? pat : ~pat);
      @(negedge clk); pin_in = '0;
      for (int b = 0; b < NB; b++) begin
        logic [31:0] ty, du, po;
        for (int i = 0; i < 32; i++) begin
          ty[i] = cfg_of(b*32+i, p)[2];
          du[i] = cfg_of(b*32+i, p)[1];
          po[i] = cfg_of(b*32+i, p)[0];
        end
        wr(12'(b*512 + 'h0C), ty);
        wr(12'(b*512 + 'h10), du);
        wr(12'(b*512 + 'h14), po);
        wr(12'(b*512 + 'h18), msk[b*32 +: 32]);
      end
      idle(4);
      for (int b = 0; b < NB; b++) wr(12'(b*512 + 'h24), 32'hFFFF_FFFF);
      idle(3);
      check_raw("R4 quiet low", p, '0, '0, '0);

      @(negedge clk); pin_in = tog;
      idle(4);
      check_raw("R5 R6 toggled high", p, tog, '0, tog);
      e64 = '0;
      for (int i = 0; i < NP; i++) e64[i] = expect_bit(cfg_of(i, p), tog[i], 1'b0, tog[i]) & msk[i];
      for (int b = 0; b < NB; b++) begin
        rd(12'(b*512 + 'h20), v);
        chk($sformatf("R9 qualified status pass %0d bank %0d", p, b), v, e64[b*32 +: 32]);
      end
      chk($sformatf("R10 irq pass %0d", p), 32'(irq), 32'(|e64));

      for (int b = 0; b < NB; b++) wr(12'(b*512 + 'h24), 32'hFFFF_FFFF);
      idle(3);
      check_raw("R7 cleared while high", p, '0, '0, tog);

      @(negedge clk); pin_in = '0;
      idle(4);
      check_raw("R4 R5 returned low", p, '0, tog, '0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      nvec++;
      nbad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule